// File: doc/BRIEF.md
# Snooping Cache Line State Controller

This block is the coherence controller of one cache in a shared-bus multiprocessor. For every line of a direct-mapped tag store it keeps a tag and three independent flag bits: valid, dirty (the line differs from memory) and shared (another cache may hold a copy). It handles local processor reads and writes. Any miss, and any write to a line that may be shared, goes to a bus request port with a request/grant handshake. At the same time it watches the transactions that other caches put on the bus.

When another cache asks to read a line that this cache holds dirty, the controller signals that it will supply the data and drops the line to clean and shared. When another cache announces a write, the controller invalidates its copy. A write that needs the bus leaves the line valid, dirty and exclusive, so this cache takes ownership of the address. The data array and the memory model are outside this block. Only tags, flag bits and control are built here.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is invalid, and `cpu_done`, `bus_req` and `supply_valid` are low. The first access to any address misses.
- R2: A read miss raises `bus_req` with `bus_cmd` = 2'b01 (read) and `bus_addr` = the request address. After the grant cycle the line is valid with the new tag, and a later read of that address completes locally with `cpu_hit` = 1.
- R3: On a read fill, the shared bit is loaded from `bus_shared_in` in the grant cycle. If it was 0, a following write completes locally. If it was 1, that write needs the bus.
- R4: A write that hits a valid line with shared = 0 completes without the bus and sets the dirty bit, so a later snooped read of that address causes a supply.
- R5: A write that hits a line with shared = 1 first raises `bus_req` with `bus_cmd` = 2'b10 (invalidate). After the grant the line is dirty and not shared, so the next write completes locally.
- R6: A write miss raises `bus_req` with `bus_cmd` = 2'b10. After the grant the line is valid, dirty and not shared under the new tag.
- R7: A snooped read (`snoop_cmd` = 2'b01) that hits a dirty line pulses `supply_valid` in the next cycle, with `supply_addr` = the snooped address. The line becomes clean and shared, so a repeated snooped read does not supply.
- R8: A snooped read that hits a clean line does not supply and sets the shared bit.
- R9: A snooped invalidate (`snoop_cmd` = 2'b10) that hits a line clears all three bits without supplying, so the next local read misses.
- R10: A snoop whose index matches a line but whose tag differs leaves that line unchanged.
- R11: In a cycle with `snoop_valid` high, `cpu_req_ready` is low. A pending processor request is accepted in the next cycle without a snoop.
- R12: `cpu_done` goes high in the cycle after a local completion or after the grant cycle, with `cpu_hit` = 1 only for completions that needed no bus. While `bus_req` waits for `bus_gnt`, the request, `bus_cmd` and `bus_addr` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address of the request |
| cpu_req_ready | output | 1 | Request accepted on this edge when valid |
| cpu_done | output | 1 | Request completed (registered) |
| cpu_hit | output | 1 | Completed without a bus transaction |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Grant; the transaction is broadcast in this cycle |
| bus_cmd | output | 2 | 00 none, 01 read, 10 invalidate |
| bus_addr | output | ADDR_W | Address of the outgoing transaction |
| bus_shared_in | input | 1 | Another cache holds the line being read (valid with the grant) |
| snoop_valid | input | 1 | Another cache's transaction is on the bus |
| snoop_cmd | input | 2 | 01 read, 10 invalidate |
| snoop_addr | input | ADDR_W | Address of the snooped transaction |
| supply_valid | output | 1 | This cache supplies the snooped line |
| supply_addr | output | ADDR_W | Address being supplied |

## Verification
The bench sweeps every line index with two tags that collide on it. For each index it walks a line through fill, share, upgrade, supply and invalidate.

Several corner cases are targeted, each with the fault it would expose:
- Clean-shared upgrade: a design that forgot the shared bit would write locally where it must request an invalidate.
- Snooped read of a dirty line: a design that kept the line dirty after supplying would supply twice.
- Same-index, different-tag snoop: a design that compared the index without the tag would corrupt an unrelated line.
- Snoop and processor request in the same cycle: a design without snoop priority would accept the request during the stall cycle.
- Grant delay: a design that dropped its request before the grant would complete too early.

// File: rtl/coh_pkg.sv
// Shared types for the snooping line state controller.
// Assumes a two-bit bus command code common to the outgoing and snooped sides.
package coh_pkg;
    typedef enum logic [1:0] {
        BUS_NONE  = 2'b00,
        BUS_READ  = 2'b01,
        BUS_INVAL = 2'b10
    } bus_cmd_e;

    typedef struct packed {
        logic v;
        logic d;
        logic s;
    } line_bits_t;
endpackage

// File: rtl/coh_line_store.sv
// Tag and flag storage, one entry per line, direct mapped.
// Two combinational lookups (processor and snoop) and two update ports.
// Assumes NUM_LINES is a power of two; a snoop update wins over a processor
// update to the same line in the same cycle.
module coh_line_store
    import coh_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int IDX_W     = 2,
    parameter int TAG_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] cpu_idx,
    input  logic [TAG_W-1:0] cpu_tag,
    output logic             cpu_hit,
    output logic             cpu_shared,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [TAG_W-1:0] snp_tag,
    output logic             snp_hit,
    output logic             snp_dirty,
    input  logic             snp_wr_en,
    input  line_bits_t       snp_wr_bits,
    input  logic             cpu_wr_en,
    input  logic [IDX_W-1:0] cpu_wr_idx,
    input  logic [TAG_W-1:0] cpu_wr_tag,
    input  line_bits_t       cpu_wr_bits
);
    line_bits_t       bits_q [NUM_LINES];
    logic [TAG_W-1:0] tag_q  [NUM_LINES];

    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(gi);
        // Update one line: snoop update first, then a processor update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bits_q[gi] <= '0;
                tag_q[gi]  <= '0;
            end else if (snp_wr_en && snp_idx == MY_IDX) begin
                bits_q[gi] <= snp_wr_bits;
            end else if (cpu_wr_en && cpu_wr_idx == MY_IDX) begin
                bits_q[gi] <= cpu_wr_bits;
                tag_q[gi]  <= cpu_wr_tag;
            end
        end
    end

    // Lookups for the processor side and the snoop side.
    always_comb begin
        cpu_hit    = bits_q[cpu_idx].v && (tag_q[cpu_idx] == cpu_tag);
        cpu_shared = bits_q[cpu_idx].s;
        snp_hit    = bits_q[snp_idx].v && (tag_q[snp_idx] == snp_tag);
        snp_dirty  = bits_q[snp_idx].d;
    end
endmodule

// File: rtl/coh_snoop_unit.sv
// Reacts to transactions of other caches: a read clears dirty and sets
// shared (supplying data if the line was dirty); an invalidate clears the line.
// Assumes the bus never shows this cache's own transaction on the snoop side.
module coh_snoop_unit
    import coh_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snoop_valid,
    input  logic [1:0]        snoop_cmd,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              hit,
    input  logic              dirty,
    output logic              wr_en,
    output line_bits_t        wr_bits,
    output logic              supply_valid,
    output logic [ADDR_W-1:0] supply_addr
);
    logic supply_d;

    // Decide the new line bits and whether data must be supplied.
    always_comb begin
        wr_en    = 1'b0;
        wr_bits  = '0;
        supply_d = 1'b0;
        if (snoop_valid && hit) begin
            case (bus_cmd_e'(snoop_cmd))
                BUS_READ: begin
                    wr_en    = 1'b1;
                    wr_bits  = '{v: 1'b1, d: 1'b0, s: 1'b1};
                    supply_d = dirty;
                end
                BUS_INVAL: begin
                    wr_en   = 1'b1;
                    wr_bits = '0;
                end
                default: ;
            endcase
        end
    end

    // Register the supply response for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            supply_valid <= 1'b0;
            supply_addr  <= '0;
        end else begin
            supply_valid <= supply_d;
            if (supply_d) supply_addr <= snoop_addr;
        end
    end
endmodule

// File: rtl/coh_cpu_ctrl.sv
// Processor-side sequencer: completes read hits and exclusive write hits
// locally; sends misses and shared-line writes to the bus and waits for grant.
// Assumes the request is held until accepted and that no snoop arrives in a
// grant cycle.
module coh_cpu_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              snoop_busy,
    input  logic              look_hit,
    input  logic              look_shared,
    output logic              done,
    output logic              done_hit,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_shared_in,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [TAG_W-1:0]  wr_tag,
    output line_bits_t        wr_bits
);
    typedef enum logic {ST_IDLE, ST_WAIT} st_e;

    st_e               st_q, st_d;
    logic [ADDR_W-1:0] pend_addr_q, pend_addr_d;
    logic              pend_wr_q, pend_wr_d;
    logic              done_d, hit_d;

    // Next-state, update and bus-request logic.
    always_comb begin
        st_d        = st_q;
        pend_addr_d = pend_addr_q;
        pend_wr_d   = pend_wr_q;
        done_d      = 1'b0;
        hit_d       = 1'b0;
        wr_en       = 1'b0;
        wr_idx      = req_addr[IDX_W-1:0];
        wr_tag      = req_addr[ADDR_W-1:IDX_W];
        wr_bits     = '0;
        req_ready   = (st_q == ST_IDLE) && !snoop_busy;
        case (st_q)
            ST_IDLE: begin
                if (req_valid && req_ready) begin
                    if (look_hit && !req_write) begin
                        done_d = 1'b1;
                        hit_d  = 1'b1;
                    end else if (look_hit && !look_shared) begin
                        wr_en   = 1'b1;
                        wr_bits = '{v: 1'b1, d: 1'b1, s: 1'b0};
                        done_d  = 1'b1;
                        hit_d   = 1'b1;
                    end else begin
                        st_d        = ST_WAIT;
                        pend_addr_d = req_addr;
                        pend_wr_d   = req_write;
                    end
                end
            end
            ST_WAIT: begin
                if (bus_gnt) begin
                    wr_en   = 1'b1;
                    wr_idx  = pend_addr_q[IDX_W-1:0];
                    wr_tag  = pend_addr_q[ADDR_W-1:IDX_W];
                    wr_bits = '{v: 1'b1, d: pend_wr_q, s: !pend_wr_q && bus_shared_in};
                    done_d  = 1'b1;
                    st_d    = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
        bus_req  = (st_q == ST_WAIT);
        bus_cmd  = (st_q == ST_WAIT) ? (pend_wr_q ? BUS_INVAL : BUS_READ) : BUS_NONE;
        bus_addr = pend_addr_q;
    end

    // State, pending request and registered completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            pend_addr_q <= '0;
            pend_wr_q   <= 1'b0;
            done        <= 1'b0;
            done_hit    <= 1'b0;
        end else begin
            st_q        <= st_d;
            pend_addr_q <= pend_addr_d;
            pend_wr_q   <= pend_wr_d;
            done        <= done_d;
            done_hit    <= hit_d;
        end
    end
endmodule

// File: rtl/coh_line_ctrl.sv
// Top of the snooping line state controller: ties the tag store, the
// processor sequencer and the snoop unit together. Snoops take the tag
// store ahead of the processor, which stalls for that cycle.
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_LINES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_req_ready,
    output logic              cpu_done,
    output logic              cpu_hit,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_shared_in,
    input  logic              snoop_valid,
    input  logic [1:0]        snoop_cmd,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              supply_valid,
    output logic [ADDR_W-1:0] supply_addr
);
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic             look_hit, look_shared, snp_hit, snp_dirty;
    logic             snp_wr_en, cpu_wr_en;
    line_bits_t       snp_wr_bits, cpu_wr_bits;
    logic [IDX_W-1:0] cpu_wr_idx;
    logic [TAG_W-1:0] cpu_wr_tag;

    coh_line_store #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_idx    (cpu_req_addr[IDX_W-1:0]),
        .cpu_tag    (cpu_req_addr[ADDR_W-1:IDX_W]),
        .cpu_hit    (look_hit),
        .cpu_shared (look_shared),
        .snp_idx    (snoop_addr[IDX_W-1:0]),
        .snp_tag    (snoop_addr[ADDR_W-1:IDX_W]),
        .snp_hit    (snp_hit),
        .snp_dirty  (snp_dirty),
        .snp_wr_en  (snp_wr_en),
        .snp_wr_bits(snp_wr_bits),
        .cpu_wr_en  (cpu_wr_en),
        .cpu_wr_idx (cpu_wr_idx),
        .cpu_wr_tag (cpu_wr_tag),
        .cpu_wr_bits(cpu_wr_bits)
    );

    coh_cpu_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) cpu_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (cpu_req_valid),
        .req_write    (cpu_req_write),
        .req_addr     (cpu_req_addr),
        .req_ready    (cpu_req_ready),
        .snoop_busy   (snoop_valid),
        .look_hit     (look_hit),
        .look_shared  (look_shared),
        .done         (cpu_done),
        .done_hit     (cpu_hit),
        .bus_req      (bus_req),
        .bus_gnt      (bus_gnt),
        .bus_cmd      (bus_cmd),
        .bus_addr     (bus_addr),
        .bus_shared_in(bus_shared_in),
        .wr_en        (cpu_wr_en),
        .wr_idx       (cpu_wr_idx),
        .wr_tag       (cpu_wr_tag),
        .wr_bits      (cpu_wr_bits)
    );

    coh_snoop_unit #(.ADDR_W(ADDR_W)) snoop_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .snoop_valid (snoop_valid),
        .snoop_cmd   (snoop_cmd),
        .snoop_addr  (snoop_addr),
        .hit         (snp_hit),
        .dirty       (snp_dirty),
        .wr_en       (snp_wr_en),
        .wr_bits     (snp_wr_bits),
        .supply_valid(supply_valid),
        .supply_addr (supply_addr)
    );
endmodule

// File: rtl/coh_line_ctrl_chk.sv
// Port-level protocol checks for coh_line_ctrl, attached by bind.
module coh_line_ctrl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_ready,
    input logic              cpu_done,
    input logic              cpu_hit,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              snoop_valid,
    input logic [1:0]        snoop_cmd,
    input logic [ADDR_W-1:0] snoop_addr,
    input logic              supply_valid,
    input logic [ADDR_W-1:0] supply_addr
);
    a_r11_snoop_stalls_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_valid |-> !cpu_req_ready);

    a_r12_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt |=> bus_req && $stable(bus_cmd) && $stable(bus_addr));

    a_r12_grant_completes: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_gnt |=> cpu_done && !cpu_hit);

    a_r7_supply_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        supply_valid |-> $past(snoop_valid) && $past(snoop_cmd) == 2'b01
                         && supply_addr == $past(snoop_addr));

    a_r9_inval_never_supplies: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_valid && snoop_cmd == 2'b10 |=> !supply_valid);

    a_r2_request_has_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_cmd != 2'b00 && !cpu_req_ready);
endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/coh_line_ctrl_tb_top.sv
module coh_line_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [7:0] cpu_req_addr = '0;
    logic       cpu_req_ready, cpu_done, cpu_hit, bus_req;
    logic       bus_gnt = 1'b0, bus_shared_in = 1'b0;
    logic [1:0] bus_cmd;
    logic [7:0] bus_addr;
    logic       snoop_valid = 1'b0;
    logic [1:0] snoop_cmd = '0;
    logic [7:0] snoop_addr = '0;
    logic       supply_valid;
    logic [7:0] supply_addr;

    int checks = 0, fails = 0;
    bit used_bus, seen_hit, held_ok, got_sup;
    logic [1:0] seen_cmd;
    logic [7:0] seen_addr, got_saddr;

    always #(CLK_PERIOD/2) clk = ~clk;

    coh_line_ctrl dut_i (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Issue one processor request; grant after dly cycles with shared flag shr.
    task automatic cpu_op(input bit wr, input logic [7:0] a, input int dly, input bit shr);
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a;
        while (!cpu_req_ready) @(negedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        used_bus = bus_req; seen_cmd = bus_cmd; seen_addr = bus_addr;
        seen_hit = 1'b0; held_ok = 1'b1;
        if (cpu_done) seen_hit = cpu_hit;
        else if (bus_req) begin
            repeat (dly) begin
                @(negedge clk);
                if (!bus_req || bus_cmd != seen_cmd || bus_addr != seen_addr) held_ok = 1'b0;
            end
            bus_gnt = 1'b1; bus_shared_in = shr;
            @(negedge clk);
            bus_gnt = 1'b0; bus_shared_in = 1'b0;
            chk("R12", "done after grant", int'(cpu_done), 1);
            seen_hit = cpu_hit;
        end
    endtask

    task automatic expect_local(input string req, input string what);
        chk(req, {what, " used bus"}, int'(used_bus), 0);
        chk(req, {what, " hit"}, int'(seen_hit), 1);
    endtask

    task automatic expect_bus(input string req, input string what, input int cmd, input logic [7:0] a);
        chk(req, {what, " used bus"}, int'(used_bus), 1);
        chk(req, {what, " cmd"}, int'(seen_cmd), cmd);
        chk(req, {what, " addr"}, int'(seen_addr), int'(a));
        chk(req, {what, " hit"}, int'(seen_hit), 0);
        chk("R12", {what, " held while waiting"}, int'(held_ok), 1);
    endtask

    // Present one snooped transaction and sample the supply response.
    task automatic snp(input logic [1:0] cmd, input logic [7:0] a);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_cmd = cmd; snoop_addr = a;
        @(negedge clk);
        snoop_valid = 1'b0;
        got_sup = supply_valid; got_saddr = supply_addr;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "cpu_done after reset", int'(cpu_done), 0);
        chk("R1", "bus_req after reset", int'(bus_req), 0);
        chk("R1", "supply_valid after reset", int'(supply_valid), 0);

        for (int i = 0; i < 4; i++) begin
            logic [7:0] a, b;
            a = {6'(i + 1), 2'(i)};
            b = {6'(i + 9), 2'(i)};
            cpu_op(1'b0, a, 1, 1'b0);
            expect_bus("R1", "first read misses", 1, a);
            cpu_op(1'b0, a, 0, 1'b0);
            expect_local("R2", "read after fill");
            snp(2'b01, a);
            chk("R8", "clean snoop read supply", int'(got_sup), 0);
            cpu_op(1'b1, a, 2, 1'b0);
            expect_bus("R5", "write to shared line", 2, a);
            cpu_op(1'b1, a, 0, 1'b0);
            expect_local("R5", "write after upgrade");
            snp(2'b01, b);
            chk("R10", "other-tag snoop supply", int'(got_sup), 0);
            cpu_op(1'b1, a, 0, 1'b0);
            expect_local("R10", "line kept exclusive");
            snp(2'b01, a);
            chk("R7", "dirty snoop supply", int'(got_sup), 1);
            chk("R7", "supply addr", int'(got_saddr), int'(a));
            snp(2'b01, a);
            chk("R7", "second snoop supply", int'(got_sup), 0);
            snp(2'b10, b);
            cpu_op(1'b0, a, 0, 1'b0);
            expect_local("R10", "read after other-tag inval");
            snp(2'b10, a);
            chk("R9", "inval supply", int'(got_sup), 0);
            cpu_op(1'b0, a, 0, 1'b1);
            expect_bus("R9", "read after inval", 1, a);
            cpu_op(1'b1, a, 1, 1'b0);
            expect_bus("R3", "write after shared fill", 2, a);
            cpu_op(1'b1, b, 3, 1'b0);
            expect_bus("R6", "write miss", 2, b);
            snp(2'b01, b);
            chk("R6", "write miss left dirty", int'(got_sup), 1);
            chk("R6", "supply addr", int'(got_saddr), int'(b));
            cpu_op(1'b0, a, 0, 1'b0);
            expect_bus("R2", "read of evicted tag", 1, a);
            cpu_op(1'b1, a, 0, 1'b0);
            expect_local("R3", "write after exclusive fill");
            snp(2'b01, a);
            chk("R4", "local write made dirty", int'(got_sup), 1);
        end

        // Snoop priority: a processor request in a snoop cycle stalls one cycle.
        cpu_op(1'b0, 8'h05, 0, 1'b0);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_cmd = 2'b01; snoop_addr = 8'hF2;
        cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = 8'h05;
        #1;
        chk("R11", "ready during snoop", int'(cpu_req_ready), 0);
        @(negedge clk);
        snoop_valid = 1'b0;
        #1;
        chk("R11", "no completion in stall", int'(cpu_done), 0);
        chk("R11", "ready after snoop", int'(cpu_req_ready), 1);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        chk("R11", "accepted after stall", int'(cpu_done), 1);
        chk("R12", "hit flag on local read", int'(cpu_hit), 1);
        @(negedge clk);
        chk("R12", "done is one cycle", int'(cpu_done), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule